// File: doc/BRIEF.md
# Four-Way Traffic Light Sequencer

This block drives the lamps of a four-road junction. It gives right of way to one approach at a time and walks through the approaches in a fixed rotation. While one approach is served, the other three show red. The served approach shows green, then yellow in two sub-phases. During the first yellow sub-phase the pedestrian crossing for that approach stays dark. During the second, yellow stays lit and the crossing's walk signal comes on. After the second sub-phase the next approach in the rotation receives green.

All timing is counted in pulses of a one-cycle tick enable, normally one per second. The start-up, green, first-yellow and second-yellow durations are separate parameters. After reset every road shows red for the start-up interval. Only then is the first green given, to north. Every lamp and walk output comes straight from a flop. No combinational glitch can therefore reach the lamp drivers.

Top module: `junction_sequencer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every direction shows red only, with yellow, green and walk all low.
- R2: After reset, all-red holds for START_TICKS tick pulses. The tick that completes it turns north (direction code 0, bit 0 of every lamp vector) green.
- R3: The outputs change only on a clock edge at which the tick enable is high. With the tick held low, every output holds its value.
- R4: At most one green is lit at any time. Every direction that is not being served shows red and nothing else.
- R5: Green on the served direction lasts GREEN_TICKS ticks. It is followed by the first yellow sub-phase, which lasts Y1_TICKS ticks. In that sub-phase the direction shows yellow with red, green and walk low.
- R6: The second yellow sub-phase lasts Y2_TICKS ticks. In it the served direction shows yellow, and its walk line is high.
- R7: When the second sub-phase ends, green moves to the next direction code. The codes are north 0, east 1, south 2 and west 3, and each code is the bit index in red_o, yellow_o, green_o and walk_o. The rotation wraps from west back to north.
- R8: A walk line is high only while its own direction is in the second yellow sub-phase. It is never high for any other direction and never together with a green.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle timing enable; every duration is counted in these pulses |
| red_o | output | 4 | Red lamp per direction, indexed by direction code |
| yellow_o | output | 4 | Yellow lamp per direction |
| green_o | output | 4 | Green lamp per direction |
| walk_o | output | 4 | Pedestrian walk signal per direction |

## Verification
The bench builds the sequencer with START_TICKS=2, GREEN_TICKS=3, Y1_TICKS=1 and Y2_TICKS=2. With these values a complete rotation through all four roads, and the wrap back to north, takes only a few dozen ticks. The single-tick first yellow sub-phase exercises the case where a phase expires on its very first tick. Ticks are spaced with idle cycles between them, so the run shows that nothing moves without a tick. A second reset in the middle of a phase shows that the start-up interval is counted afresh.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    localparam int DIR_W    = 2;
    localparam int NUM_DIRS = 1 << DIR_W;

    typedef enum logic [1:0] {
        PH_GREEN = 2'd0,
        PH_Y1    = 2'd1,
        PH_Y2    = 2'd2,
        PH_BAD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic             startup;
        logic [DIR_W-1:0] dir;
        phase_e           phase;
    } ctl_t;

    typedef struct packed {
        logic [NUM_DIRS-1:0] red;
        logic [NUM_DIRS-1:0] yel;
        logic [NUM_DIRS-1:0] grn;
        logic [NUM_DIRS-1:0] walk;
    } lamps_t;

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          tick_i,
    input  logic          restart_i,
    input  logic [CW-1:0] limit_i,
    output logic          expire_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = tick_i && !restart_i && (cnt_q == limit_i - 1'b1);
        cnt_d    = cnt_q;
        if (restart_i || expire_o) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R5: the tick count in a phase never reaches the phase length
    assert_count_in_range_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q < limit_i);

endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
    import tlc_pkg::*;
(
    input  ctl_t                ctl_i,
    output logic [NUM_DIRS-1:0] red_o,
    output logic [NUM_DIRS-1:0] yel_o,
    output logic [NUM_DIRS-1:0] grn_o,
    output logic [NUM_DIRS-1:0] walk_o
);

    for (genvar i = 0; i < NUM_DIRS; i++) begin : g_dir
        logic served;
        assign served    = !ctl_i.startup && (ctl_i.dir == DIR_W'(i));
        assign red_o[i]  = !served || (ctl_i.phase == PH_BAD);
        assign grn_o[i]  = served && (ctl_i.phase == PH_GREEN);
        assign yel_o[i]  = served && ((ctl_i.phase == PH_Y1) || (ctl_i.phase == PH_Y2));
        assign walk_o[i] = served && (ctl_i.phase == PH_Y2);
    end

endmodule

// File: rtl/junction_sequencer.sv
module junction_sequencer
    import tlc_pkg::*;
#(
    parameter int START_TICKS = 2,
    parameter int GREEN_TICKS = 10,
    parameter int Y1_TICKS    = 2,
    parameter int Y2_TICKS    = 3
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_i,
    output logic [3:0] red_o,
    output logic [3:0] yellow_o,
    output logic [3:0] green_o,
    output logic [3:0] walk_o
);

    localparam int MAX_AB  = (START_TICKS > GREEN_TICKS) ? START_TICKS : GREEN_TICKS;
    localparam int MAX_CD  = (Y1_TICKS > Y2_TICKS) ? Y1_TICKS : Y2_TICKS;
    localparam int MAX_T   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW      = $clog2(MAX_T + 1);

    ctl_t          ctl_d, ctl_q;
    lamps_t        lamps_d, lamps_q;
    logic [CW-1:0] limit;
    logic          restart;
    logic          expire;

    phase_timer #(.CW(CW)) u_timer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick_i),
        .restart_i (restart),
        .limit_i   (limit),
        .expire_o  (expire)
    );

    always_comb begin
        ctl_d   = ctl_q;
        restart = 1'b0;
        if (ctl_q.startup) begin
            limit = CW'(START_TICKS);
        end else begin
            case (ctl_q.phase)
                PH_GREEN: limit = CW'(GREEN_TICKS);
                PH_Y1:    limit = CW'(Y1_TICKS);
                PH_Y2:    limit = CW'(Y2_TICKS);
                default:  limit = CW'(START_TICKS);
            endcase
        end

        if (ctl_q.startup) begin
            if (expire) begin
                ctl_d.startup = 1'b0;
                ctl_d.dir     = '0;
                ctl_d.phase   = PH_GREEN;
            end
        end else begin
            case (ctl_q.phase)
                PH_GREEN: if (expire) ctl_d.phase = PH_Y1;
                PH_Y1:    if (expire) ctl_d.phase = PH_Y2;
                PH_Y2: begin
                    if (expire) begin
                        ctl_d.dir   = ctl_q.dir + 1'b1;
                        ctl_d.phase = PH_GREEN;
                    end
                end
                default: begin
                    ctl_d.startup = 1'b1;
                    ctl_d.dir     = '0;
                    ctl_d.phase   = PH_GREEN;
                    restart       = 1'b1;
                end
            endcase
        end
    end

    lamp_decode u_decode (
        .ctl_i  (ctl_d),
        .red_o  (lamps_d.red),
        .yel_o  (lamps_d.yel),
        .grn_o  (lamps_d.grn),
        .walk_o (lamps_d.walk)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q.startup <= 1'b1;
            ctl_q.dir     <= '0;
            ctl_q.phase   <= PH_GREEN;
            lamps_q.red   <= '1;
            lamps_q.yel   <= '0;
            lamps_q.grn   <= '0;
            lamps_q.walk  <= '0;
        end else begin
            ctl_q   <= ctl_d;
            lamps_q <= lamps_d;
        end
    end

    assign red_o    = lamps_q.red;
    assign yellow_o = lamps_q.yel;
    assign green_o  = lamps_q.grn;
    assign walk_o   = lamps_q.walk;

    // R4: never two greens at once
    assert_single_green_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(lamps_q.grn));

    // R8: walk only with yellow on the same road
    assert_walk_with_yellow_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (lamps_q.walk & ~lamps_q.yel) == '0);

    // R3: no tick, no change
    assert_hold_without_tick_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> $stable(lamps_q));

    // R7: leaving Y2 moves green to the next direction code
    assert_rotation_step_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl_q.phase == PH_GREEN && $past(ctl_q.phase) == PH_Y2 && !ctl_q.startup)
        |-> ctl_q.dir == $past(ctl_q.dir) + 2'd1);

endmodule

// File: tb/junction_sequencer_test.sv
`timescale 1ns/1ps
module junction_sequencer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [3:0] red, yellow, green, walk;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    junction_sequencer #(
        .START_TICKS (2),
        .GREEN_TICKS (3),
        .Y1_TICKS    (1),
        .Y2_TICKS    (2)
    ) uut (
        .clk_i    (clk),
        .rst_i    (rst),
        .tick_i   (tick),
        .red_o    (red),
        .yellow_o (yellow),
        .green_o  (green),
        .walk_o   (walk)
    );

    // {ticks, red, yellow, green, walk}: pattern held for that many ticks
    localparam logic [19:0] STEPS [0:13] = '{
        20'h2F000,                                   // R2 start-up all red
        20'h3E010, 20'h1E100, 20'h2E101,             // north
        20'h3D020, 20'h1D200, 20'h2D202,             // east
        20'h3B040, 20'h1B400, 20'h2B404,             // south
        20'h37080, 20'h17800, 20'h27808,             // west
        20'h3E010                                    // R7 wrap to north
    };

    function automatic logic [15:0] lamps();
        return {red, yellow, green, walk};
    endfunction

    task automatic expect_lamps(input logic [15:0] exp, input string tag);
        checks++;
        if (lamps() !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, lamps(), exp);
        end
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    // R4 and R8 on every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (!$onehot0(green) || ((red | yellow | green) != 4'hF) ||
                ((red & yellow) | (red & green) | (yellow & green)) != 4'h0) begin
                errors++;
                $display("FAIL R4 got red %h yellow %h green %h expected one lamp per road, <=1 green",
                         red, yellow, green);
            end
            checks++;
            if ((walk & ~yellow) != 4'h0 || (walk & green) != 4'h0) begin
                errors++;
                $display("FAIL R8 got walk %h yellow %h green %h expected walk inside yellow",
                         walk, yellow, green);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        expect_lamps(16'hF000, "R1 in reset");
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        expect_lamps(16'hF000, "R1 tick during reset");
        rst = 1'b0;
        @(negedge clk);
        expect_lamps(16'hF000, "R1 after reset release");

        // rotation table: R2 R5 R6 R7
        for (int s = 0; s < 14; s++) begin
            for (int k = 0; k < int'(STEPS[s][19:16]); k++) begin
                expect_lamps(STEPS[s][15:0], $sformatf("R2/R5/R6/R7 step %0d tick %0d", s, k));
                pulse_tick();
            end
        end
        expect_lamps(16'hE100, "R5 north Y1 after second rotation green");

        // R3: hold with no tick
        pulse_tick();
        held = lamps();
        expect_lamps(16'hE101, "R6 north Y2 walk on");
        for (int c = 0; c < 25; c++) begin
            @(negedge clk);
            expect_lamps(held, "R3 hold without tick");
        end
        pulse_tick();
        expect_lamps(16'hE101, "R6 north Y2 second tick");
        pulse_tick();
        expect_lamps(16'hD020, "R7 east green after north");

        // mid-phase reset
        pulse_tick();
        rst = 1'b1;
        @(negedge clk);
        expect_lamps(16'hF000, "R1 mid-run reset");
        rst = 1'b0;
        @(negedge clk);
        expect_lamps(16'hF000, "R1 first cycle after mid-run reset");
        pulse_tick();
        expect_lamps(16'hF000, "R2 start-up counted afresh");
        pulse_tick();
        expect_lamps(16'hE010, "R2 north green after start-up");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule